// File: doc/BRIEF.md
# Multicast hash address filter

This block decides whether a received 48-bit destination address is let through by a 64-bit multicast hash filter. A start strobe captures the address as a parallel word. A CRC engine then walks over the 48 address bits and reduces them to a 6-bit hash, and that hash picks one bit of the filter. When the work is complete the block raises a one-cycle done pulse. With the pulse it presents the accept decision, the computed hash and a flag that marks the address as multicast. Host software can read the hash to learn which filter bit to set for a group address.

The filter is held as eight bytes, and the host writes them one byte at a time. Two mode controls widen acceptance. The first lets every multicast address through whatever the filter holds. The second, promiscuous mode, lets every address through. The parameter `STEPS_PER_CYCLE` sets how many CRC bit steps run in one clock, from fully bit-serial (1) to a single cycle (48). It must divide 48.

Top module: `mc_hash_filter`

## Requirements
- R1: After reset `done`, `accept`, `mcast` and `hash` are 0, all 64 filter bits are clear and both mode controls are off.
- R2: The hash is a CRC over the address using generator 0x04C11DB7 with a state of all ones at the start. Bits are fed from addr[0] up to addr[47]; addr[7:0] is byte 0, and bit 0 of each byte goes first. On each step the feedback is the input bit XOR state bit 31; the state shifts up by one and, when the feedback is 1, is XORed with the generator. The hash is formed as hash[5-k] = state[k] for k = 0..5, so the newest bit is the MSB.
- R3: `done` is a one-cycle pulse. It rises in the cycle after the 48/STEPS_PER_CYCLE-th processing edge that follows the edge at which `start` was sampled (48 cycles for the bit-serial form). `hash`, `accept` and `mcast` are updated only with `done` and hold until the next `done`.
- R4: An address is multicast when addr[0] is 1, and `mcast` then reads 1. With both modes off, a multicast address is accepted exactly when bit hash[2:0] of filter byte hash[5:3] is 1.
- R5: A write with `flt_we` high stores `flt_data` into filter byte `flt_sel` (0..7) and leaves the other seven bytes unchanged.
- R6: With promiscuous mode off, a non-multicast address gets `accept` = 0 whatever the filter holds.
- R7: A write with `mode_we` high loads both mode controls from `allmc_d` and `promisc_d`. With the all-multicast control set, every multicast address is accepted as if all filter bits were 1.
- R8: With the promiscuous control set, every address is accepted.
- R9: A `start` that arrives while a hash is in progress abandons that hash and begins again with the new address. Only one `done` follows, and it carries the result for the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Captures `addr` and begins hashing |
| addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| flt_we | input | 1 | Filter byte write enable |
| flt_sel | input | 3 | Filter byte index |
| flt_data | input | 8 | Filter byte value |
| mode_we | input | 1 | Mode control write enable |
| promisc_d | input | 1 | Promiscuous control value |
| allmc_d | input | 1 | Accept-all-multicast control value |
| done | output | 1 | One-cycle result pulse |
| accept | output | 1 | Address passes the filter |
| mcast | output | 1 | Address is multicast |
| hash | output | 6 | Computed filter index |

## Verification
The bench uses the default STEPS_PER_CYCLE of 1, the fully bit-serial form. This setting makes the 48-cycle latency and the restart in the middle of a hash observable; the unrolled forms reach neither. The bench's own CRC model computes the expected hash for each address. A partly filled filter shows that only the selected byte and bit decide the result. Random multicast addresses run against random filter contents spread the hash over many of the 64 positions.

// File: rtl/mc_hash_filter.sv
module mc_hash_filter #(
  parameter int STEPS_PER_CYCLE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] addr,
  input  logic        flt_we,
  input  logic [2:0]  flt_sel,
  input  logic [7:0]  flt_data,
  input  logic        mode_we,
  input  logic        promisc_d,
  input  logic        allmc_d,
  output logic        done,
  output logic        accept,
  output logic        mcast,
  output logic [5:0]  hash
);
  localparam int          ADDR_W = 48;
  localparam int          NSTEP  = ADDR_W / STEPS_PER_CYCLE;
  localparam int          CW     = $clog2(NSTEP + 1);
  localparam logic [31:0] POLY   = 32'h04C1_1DB7;

  function automatic logic [31:0] crc_step(input logic [31:0] s, input logic b);
    logic [31:0] r;
    r = {s[30:0], 1'b0};
    if (b ^ s[31]) r = r ^ POLY;
    return r;
  endfunction

  logic [31:0]   crc_q;
  logic [47:0]   addr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, mc_q;
  logic          promisc_q, allmc_q;
  logic [7:0]    filt_q [8];
  logic          done_q, accept_q, mcast_q;
  logic [5:0]    hash_q;

  logic [31:0] chain [STEPS_PER_CYCLE+1];
  assign chain[0] = crc_q;

  for (genvar g = 0; g < STEPS_PER_CYCLE; g++) begin : g_step
    assign chain[g+1] = crc_step(chain[g], addr_q[g]);
  end

  logic [5:0] nhash;
  always_comb
    for (int k = 0; k < 6; k++) nhash[5-k] = chain[STEPS_PER_CYCLE][k];

  logic [7:0] sel_byte;
  logic       hit, last_step;
  assign sel_byte  = filt_q[nhash[5:3]];
  assign hit       = sel_byte[nhash[2:0]];
  assign last_step = (cnt_q == CW'(NSTEP - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q    <= '1;
      addr_q   <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      mc_q     <= 1'b0;
      done_q   <= 1'b0;
      accept_q <= 1'b0;
      mcast_q  <= 1'b0;
      hash_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        crc_q  <= '1;
        addr_q <= addr;
        cnt_q  <= '0;
        busy_q <= 1'b1;
        mc_q   <= addr[0];
      end else if (busy_q) begin
        crc_q  <= chain[STEPS_PER_CYCLE];
        addr_q <= addr_q >> STEPS_PER_CYCLE;
        cnt_q  <= cnt_q + 1'b1;
        if (last_step) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          hash_q   <= nhash;
          mcast_q  <= mc_q;
          accept_q <= promisc_q | (mc_q & (allmc_q | hit));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) filt_q[i] <= '0;
      promisc_q <= 1'b0;
      allmc_q   <= 1'b0;
    end else begin
      if (flt_we) filt_q[flt_sel] <= flt_data;
      if (mode_we) begin
        promisc_q <= promisc_d;
        allmc_q   <= allmc_d;
      end
    end
  end

  assign done   = done_q;
  assign accept = accept_q;
  assign mcast  = mcast_q;
  assign hash   = hash_q;
endmodule

// File: rtl/mc_hash_filter_chk.sv
module mc_hash_filter_chk #(
  parameter int STEPS_PER_CYCLE = 1
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic done,
  input logic accept,
  input logic mcast,
  input logic promisc_q,
  input logic allmc_q
);
  localparam int NSTEP = 48 / STEPS_PER_CYCLE;

  logic [7:0] lat;
  always_ff @(posedge clk) begin
    if (!rst_n)            lat <= '0;
    else if (start)        lat <= 8'd1;
    else if (done)         lat <= '0;
    else if (lat != 8'd0)  lat <= lat + 8'd1;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat == 8'(NSTEP + 1)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(accept) && $stable(mcast)); // R3
  AST_UNICAST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mcast && !$past(promisc_q)) |-> !accept); // R6
  AST_ALLMC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mcast && $past(allmc_q)) |-> accept); // R7
  AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(promisc_q)) |-> accept); // R8
endmodule

bind mc_hash_filter mc_hash_filter_chk #(.STEPS_PER_CYCLE(STEPS_PER_CYCLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .accept(accept),
  .mcast(mcast), .promisc_q(promisc_q), .allmc_q(allmc_q)
);

// File: tb/test_mc_hash_filter.sv
module test_mc_hash_filter;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [47:0] addr = '0;
  logic flt_we = 1'b0, mode_we = 1'b0, promisc_d = 1'b0, allmc_d = 1'b0;
  logic [2:0] flt_sel = '0;
  logic [7:0] flt_data = '0;
  logic done, accept, mcast;
  logic [5:0] hash;

  mc_hash_filter i_mc_hash_filter (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;

  typedef struct { logic [5:0] h; logic acc; logic mc; string tag; } exp_t;
  exp_t sb[$];

  logic [7:0] m_filt [8];
  logic m_prom = 1'b0, m_allmc = 1'b0;

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [32:0] st;
    logic [5:0] h;
    st = '1;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = a[i] ^ st[31];
      st = {st[31:0], 1'b0};
      if (fb) st[31:0] = st[31:0] ^ 32'h04C11DB7;
    end
    for (int k = 0; k < 6; k++) h[5-k] = st[k];
    return h;
  endfunction

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected done actual 1 expected 0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " hash"}, 48'(hash), 48'(e.h));
        chk({e.tag, " accept"}, 48'(accept), 48'(e.acc));
        chk({e.tag, " mcast"}, 48'(mcast), 48'(e.mc));
      end
    end
  end

  function automatic exp_t expect_for(input logic [47:0] a, input string tag);
    exp_t e;
    logic [7:0] b;
    e.h = ref_hash(a);
    e.mc = a[0];
    b = m_filt[e.h[5:3]];
    e.acc = m_prom | (a[0] & (m_allmc | b[e.h[2:0]]));
    e.tag = tag;
    return e;
  endfunction

  task automatic wait_done(input string tag);
    int n = 0;
    while (1) begin
      @(negedge clk);
      n++;
      if (done || n > 200) break;
    end
    chk({tag, " latency R3"}, 48'(n), 48'd48);
  endtask

  task automatic send(input logic [47:0] a, input string tag);
    sb.push_back(expect_for(a, tag));
    @(negedge clk); start = 1'b1; addr = a;
    @(negedge clk); start = 1'b0;
    wait_done(tag);
    @(negedge clk);
  endtask

  task automatic wr_flt(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); flt_we = 1'b1; flt_sel = s; flt_data = d;
    @(negedge clk); flt_we = 1'b0;
    m_filt[s] = d;
  endtask

  task automatic set_mode(input logic p, input logic am);
    @(negedge clk); mode_we = 1'b1; promisc_d = p; allmc_d = am;
    @(negedge clk); mode_we = 1'b0;
    m_prom = p; m_allmc = am;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 8; i++) m_filt[i] = '0;
    m_prom = 1'b0; m_allmc = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [47:0] mc_a, uc_a, a2;
    logic [5:0] h;
    for (int i = 0; i < 8; i++) m_filt[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset done",   48'(done),   48'd0);
    chk("R1 reset accept", 48'(accept), 48'd0);
    chk("R1 reset mcast",  48'(mcast),  48'd0);
    chk("R1 reset hash",   48'(hash),   48'd0);

    mc_a = 48'h5634_1200_5E01;
    uc_a = 48'hEFCD_AB89_6700;
    h = ref_hash(mc_a);

    send(mc_a, "R1 empty filter");
    send(48'hFFFF_FFFF_FFFF, "R2 broadcast");
    send(48'h0000_0000_0001, "R2 sparse");

    wr_flt(h[5:3], ~(8'd1 << h[2:0]));
    send(mc_a, "R4 bit clear");
    for (int i = 0; i < 8; i++)
      if (3'(i) != h[5:3]) wr_flt(3'(i), 8'hFF);
    send(mc_a, "R5 other bytes");
    wr_flt(h[5:3], 8'd1 << h[2:0]);
    send(mc_a, "R4 bit set");

    for (int i = 0; i < 8; i++) wr_flt(3'(i), 8'hFF);
    send(uc_a, "R6 unicast full filter");

    for (int i = 0; i < 8; i++) wr_flt(3'(i), 8'h00);
    set_mode(1'b0, 1'b1);
    send(mc_a, "R7 allmc multicast");
    send(uc_a, "R7 allmc unicast");

    set_mode(1'b1, 1'b0);
    send(uc_a, "R8 promisc unicast");
    send(mc_a, "R8 promisc multicast");

    set_mode(1'b0, 1'b0);
    wr_flt(h[5:3], 8'hFF);
    do_reset();
    send(mc_a, "R1 filter cleared");

    a2 = 48'h0102_0304_0533;
    sb.push_back(expect_for(a2, "R9 restart"));
    @(negedge clk); start = 1'b1; addr = uc_a;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    start = 1'b1; addr = a2;
    @(negedge clk); start = 1'b0;
    wait_done("R9 restart");
    repeat (60) @(negedge clk);
    chk("R9 queue drained", 48'(sb.size()), 48'd0);

    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < 8; i++) wr_flt(3'(i), 8'($urandom));
      send({$urandom, 16'($urandom)} | 48'd1, "R2 R4 random");
    end

    repeat (5) @(negedge clk);
    chk("R3 no pending result", 48'(sb.size()), 48'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule